// File: doc/BRIEF.md
# Out-of-Order Ready-Entry Lane Picker

This block holds a small issue window and, every clock cycle, decides which waiting entries go to a set of identical execution lanes. Each entry carries the tag of the result it will produce and the tags of its source operands, with one ready flag per operand. The window is walked from the oldest entry to the youngest. Every entry whose operands are all available is given the lowest-numbered lane that is still free. An entry that is still waiting is passed over, and younger ready entries may issue ahead of it. Lanes left over after the walk stay idle.

Age is set by allocation order, not by slot number. An external allocator writes one entry per cycle into a free slot. Issued entries leave the window at the end of their cycle. The destination tags of the issued entries are broadcast to the window in the same cycle, so their consumers can be selected in the following cycle. That is the back-to-back timing of single-cycle operations. Grants are registered: the selection made from the window contents in cycle t appears on the grant ports just after the clock edge that ends cycle t.

Top module: `lane_picker`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every bit of `grant_vld` and `issued_mask` is 0 and the window is empty.
- R2: Entries are ranked by allocation order, not by slot number. The oldest ready entry goes to lane 0, the next oldest ready entry to lane 1, and so on.
- R3: Lane r reports the granted slot number in `grant_idx[r*IDX_W +: IDX_W]`. Bit i of `issued_mask` is 1 exactly when slot i is granted on some lane in that cycle.
- R4: An entry with any operand not ready is skipped. Younger entries that are ready still issue in the same cycle.
- R5: Lanes fill from lane 0 upward without gaps. A lane with no remaining ready entry has `grant_vld[r]` = 0 and index 0.
- R6: At most LANES entries are granted per cycle. Ready entries beyond that limit are granted in later cycles, still in age order.
- R7: A granted entry leaves the window at the end of its cycle and is never granted a second time.
- R8: A granted entry's destination tag marks matching operands ready from the next cycle on. A consumer's grant therefore appears exactly one cycle after its producer's grant, and never in the same cycle.
- R9: An operand being allocated whose tag matches a destination tag broadcast in the allocation cycle is stored as ready.
- R10: An allocation aimed at a slot that is still occupied is ignored. It changes neither that entry's contents nor its age.
- R11: An entry written with all operands ready is granted in the cycle after its allocation. Its grant is visible one cycle after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Write one entry this cycle |
| alloc_slot | input | IDX_W | Target slot of the write |
| alloc_dst | input | TAG_W | Tag of the result the entry produces |
| alloc_src | input | SRCS*TAG_W | Source operand tags, operand s at [s*TAG_W +: TAG_W] |
| alloc_src_rdy | input | SRCS | Operand s already available |
| grant_vld | output | LANES | Lane r carries a grant |
| grant_idx | output | LANES*IDX_W | Granted slot per lane |
| issued_mask | output | ENTRIES | Slots granted this cycle |

## Verification
A lost or stuck operand-ready flag shows as an entry that never reaches a lane, or one that reaches a lane one cycle early next to its producer. Either is visible at the first grant after the producer issues. A corrupted age relation swaps two slot numbers across lanes the first time two of the affected entries are ready together. A valid bit that fails to clear repeats a slot in `issued_mask` in the very next cycle. The directed sequences place slots in reverse and scrambled order, and they hold entries back on chosen tags, so that each of these faults shows within one or two cycles of the release.

// File: rtl/pick_pkg.sv
package pick_pkg;

  localparam int unsigned PK_ENTRIES = 8;
  localparam int unsigned PK_LANES   = 4;
  localparam int unsigned PK_TAG_W   = 5;
  localparam int unsigned PK_SRCS    = 2;

  // population count over a zero-extended vector
  function automatic int unsigned ones_in(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < 64; k++) n += int'(v[k]);
    return n;
  endfunction

endpackage

// File: rtl/pick_age_order.sv
// Pairwise age relation: bit (i*ENTRIES + j) set means slot i is older than slot j.
module pick_age_order #(
  parameter int unsigned ENTRIES = pick_pkg::PK_ENTRIES,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [IDX_W-1:0]             slot,
  output logic [ENTRIES*ENTRIES-1:0]   older
);

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_row
    for (genvar gj = 0; gj < ENTRIES; gj++) begin : g_col
      if (gi == gj) begin : g_diag
        assign older[gi*ENTRIES + gj] = 1'b0;
      end else begin : g_pair
        logic bit_q;
        always_ff @(posedge clk) begin
          if (rst) begin
            bit_q <= 1'b0;
          end else if (we && slot == IDX_W'(gj)) begin
            bit_q <= 1'b1;   // every other slot is older than the newcomer
          end else if (we && slot == IDX_W'(gi)) begin
            bit_q <= 1'b0;   // the newcomer is older than nobody
          end
        end
        assign older[gi*ENTRIES + gj] = bit_q;
      end
    end
  end

endmodule

// File: rtl/pick_slot.sv
// One window entry: valid flag, destination tag, source tags with wakeup.
module pick_slot #(
  parameter int unsigned TAG_W = pick_pkg::PK_TAG_W,
  parameter int unsigned SRCS  = pick_pkg::PK_SRCS,
  parameter int unsigned LANES = pick_pkg::PK_LANES
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic [TAG_W-1:0]        in_dst,
  input  logic [SRCS*TAG_W-1:0]   in_src,
  input  logic [SRCS-1:0]         in_rdy,
  input  logic                    leave,
  input  logic [LANES-1:0]        bc_vld,
  input  logic [LANES*TAG_W-1:0]  bc_tag,
  output logic                    valid_o,
  output logic                    ready_o,
  output logic [TAG_W-1:0]        dst_o
);

  logic             valid_q;
  logic [TAG_W-1:0] dst_q;
  logic [SRCS-1:0]  src_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (take) begin
      valid_q <= 1'b1;
    end else if (leave) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) dst_q <= in_dst;
  end

  for (genvar gs = 0; gs < SRCS; gs++) begin : g_src
    logic [TAG_W-1:0] tag_q;
    logic             ok_q;
    logic             hit_new;
    logic             hit_held;

    always_comb begin
      hit_new  = 1'b0;
      hit_held = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (bc_vld[l] && bc_tag[l*TAG_W +: TAG_W] == in_src[gs*TAG_W +: TAG_W]) hit_new = 1'b1;
        if (bc_vld[l] && bc_tag[l*TAG_W +: TAG_W] == tag_q) hit_held = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ok_q  <= 1'b0;
        tag_q <= '0;
      end else if (take) begin
        tag_q <= in_src[gs*TAG_W +: TAG_W];
        ok_q  <= in_rdy[gs] | hit_new;
      end else if (valid_q) begin
        ok_q  <= ok_q | hit_held;
      end
    end

    assign src_ok[gs] = ok_q;
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q & (&src_ok);
  assign dst_o   = dst_q;

endmodule

// File: rtl/pick_select.sv
// Rank each candidate by the number of older candidates; rank r lands on lane r.
module pick_select #(
  parameter int unsigned ENTRIES = pick_pkg::PK_ENTRIES,
  parameter int unsigned LANES   = pick_pkg::PK_LANES,
  parameter int unsigned TAG_W   = pick_pkg::PK_TAG_W,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]          cand,
  input  logic [ENTRIES*ENTRIES-1:0]  older,
  input  logic [ENTRIES*TAG_W-1:0]    dst,
  output logic [LANES-1:0]            sel_vld,
  output logic [LANES*IDX_W-1:0]      sel_idx,
  output logic [ENTRIES-1:0]          sel_mask,
  output logic [LANES*TAG_W-1:0]      sel_dst
);

  logic [ENTRIES*LANES-1:0] hit;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    logic [ENTRIES-1:0] ahead;
    int unsigned        rank;

    always_comb begin
      for (int j = 0; j < ENTRIES; j++) ahead[j] = cand[j] & older[j*ENTRIES + gi];
      rank = pick_pkg::ones_in(64'(ahead));
    end

    assign sel_mask[gi] = cand[gi] && (rank < LANES);

    for (genvar gr = 0; gr < LANES; gr++) begin : g_lane_hit
      assign hit[gi*LANES + gr] = cand[gi] && (rank == gr);
    end
  end

  for (genvar gr = 0; gr < LANES; gr++) begin : g_lane
    logic             l_vld;
    logic [IDX_W-1:0] l_idx;
    logic [TAG_W-1:0] l_dst;

    always_comb begin
      l_vld = 1'b0;
      l_idx = '0;
      l_dst = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (hit[i*LANES + gr]) begin
          l_vld = 1'b1;
          l_idx = l_idx | IDX_W'(i);
          l_dst = l_dst | dst[i*TAG_W +: TAG_W];
        end
      end
    end

    assign sel_vld[gr]                 = l_vld;
    assign sel_idx[gr*IDX_W +: IDX_W]  = l_idx;
    assign sel_dst[gr*TAG_W +: TAG_W]  = l_dst;
  end

endmodule

// File: rtl/lane_picker.sv
module lane_picker #(
  parameter int unsigned ENTRIES = pick_pkg::PK_ENTRIES,
  parameter int unsigned LANES   = pick_pkg::PK_LANES,
  parameter int unsigned TAG_W   = pick_pkg::PK_TAG_W,
  parameter int unsigned SRCS    = pick_pkg::PK_SRCS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_en,
  input  logic [$clog2(ENTRIES)-1:0]    alloc_slot,
  input  logic [TAG_W-1:0]              alloc_dst,
  input  logic [SRCS*TAG_W-1:0]         alloc_src,
  input  logic [SRCS-1:0]               alloc_src_rdy,
  output logic [LANES-1:0]              grant_vld,
  output logic [LANES*$clog2(ENTRIES)-1:0] grant_idx,
  output logic [ENTRIES-1:0]            issued_mask
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]         slot_valid;
  logic [ENTRIES-1:0]         slot_ready;
  logic [ENTRIES*TAG_W-1:0]   slot_dst;
  logic [ENTRIES-1:0]         take;
  logic                       accept;
  logic [ENTRIES*ENTRIES-1:0] older;
  logic [LANES-1:0]           sel_vld;
  logic [LANES*IDX_W-1:0]     sel_idx;
  logic [ENTRIES-1:0]         sel_mask;
  logic [LANES*TAG_W-1:0]     sel_dst;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_win
    assign take[gi] = alloc_en && (alloc_slot == IDX_W'(gi)) && !slot_valid[gi];

    pick_slot #(
      .TAG_W (TAG_W),
      .SRCS  (SRCS),
      .LANES (LANES)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .take    (take[gi]),
      .in_dst  (alloc_dst),
      .in_src  (alloc_src),
      .in_rdy  (alloc_src_rdy),
      .leave   (sel_mask[gi]),
      .bc_vld  (sel_vld),
      .bc_tag  (sel_dst),
      .valid_o (slot_valid[gi]),
      .ready_o (slot_ready[gi]),
      .dst_o   (slot_dst[gi*TAG_W +: TAG_W])
    );
  end

  assign accept = |take;

  pick_age_order #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_age (
    .clk   (clk),
    .rst   (rst),
    .we    (accept),
    .slot  (alloc_slot),
    .older (older)
  );

  pick_select #(
    .ENTRIES (ENTRIES),
    .LANES   (LANES),
    .TAG_W   (TAG_W),
    .IDX_W   (IDX_W)
  ) u_sel (
    .cand     (slot_ready),
    .older    (older),
    .dst      (slot_dst),
    .sel_vld  (sel_vld),
    .sel_idx  (sel_idx),
    .sel_mask (sel_mask),
    .sel_dst  (sel_dst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vld   <= '0;
      grant_idx   <= '0;
      issued_mask <= '0;
    end else begin
      grant_vld   <= sel_vld;
      grant_idx   <= sel_idx;
      issued_mask <= sel_mask;
    end
  end

endmodule

// File: rtl/pick_chk.sv
module pick_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned LANES   = 4,
  parameter int unsigned IDX_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [LANES-1:0]         grant_vld,
  input logic [LANES*IDX_W-1:0]   grant_idx,
  input logic [ENTRIES-1:0]       issued_mask
);

  // R5: valid lanes form a run starting at lane 0
  p_lanes_packed_r5: assert property (@(posedge clk) disable iff (rst)
    ((grant_vld & (grant_vld + LANES'(1))) == '0));

  // R6: one mask bit per valid lane, never more than the lane count
  p_width_limit_r6: assert property (@(posedge clk) disable iff (rst)
    ($countones(issued_mask) == $countones(grant_vld)));

  // R7: a slot granted in one cycle is not granted again in the next
  p_single_issue_r7: assert property (@(posedge clk) disable iff (rst)
    (|issued_mask) |=> ((issued_mask & $past(issued_mask)) == '0));

  for (genvar gr = 0; gr < LANES; gr++) begin : g_lane
    // R3: every lane's slot appears in the issued mask
    p_lane_in_mask_r3: assert property (@(posedge clk) disable iff (rst)
      grant_vld[gr] |-> issued_mask[grant_idx[gr*IDX_W +: IDX_W]]);
    // R5: idle lanes carry index zero
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
      !grant_vld[gr] |-> (grant_idx[gr*IDX_W +: IDX_W] == '0));
  end

endmodule

bind lane_picker pick_chk #(
  .ENTRIES (ENTRIES),
  .LANES   (LANES),
  .IDX_W   ($clog2(ENTRIES))
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .grant_vld   (grant_vld),
  .grant_idx   (grant_idx),
  .issued_mask (issued_mask)
);

// File: tb/sim_lane_picker.sv
module sim_lane_picker;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int NL = 4;
  localparam int TW = 5;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            alloc_en = 1'b0;
  logic [IW-1:0]   alloc_slot = '0;
  logic [TW-1:0]   alloc_dst = '0;
  logic [2*TW-1:0] alloc_src = '0;
  logic [1:0]      alloc_src_rdy = '0;
  logic [NL-1:0]   grant_vld;
  logic [NL*IW-1:0] grant_idx;
  logic [NE-1:0]   issued_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_picker #(.ENTRIES(NE), .LANES(NL), .TAG_W(TW), .SRCS(2)) u0 (
    .clk(clk), .rst(rst), .alloc_en(alloc_en), .alloc_slot(alloc_slot),
    .alloc_dst(alloc_dst), .alloc_src(alloc_src), .alloc_src_rdy(alloc_src_rdy),
    .grant_vld(grant_vld), .grant_idx(grant_idx), .issued_mask(issued_mask)
  );

  // write one entry; called at a falling edge, returns one cycle later
  task automatic put(int slot, int dst, int s0, bit r0, int s1, bit r1);
    alloc_en      = 1'b1;
    alloc_slot    = IW'(slot);
    alloc_dst     = TW'(dst);
    alloc_src     = {TW'(s1), TW'(s0)};
    alloc_src_rdy = {r1, r0};
    @(negedge clk);
    alloc_en      = 1'b0;
  endtask

  task automatic expect_out(string req, logic [NL-1:0] ev, int i0, int i1, int i2, int i3,
                            logic [NE-1:0] em);
    int want[NL];
    want = '{i0, i1, i2, i3};
    checks++;
    if (grant_vld !== ev) begin
      fails++;
      $display("FAIL %s grant_vld actual=%b expected=%b", req, grant_vld, ev);
    end
    for (int r = 0; r < NL; r++) begin
      logic [IW-1:0] e;
      e = ev[r] ? IW'(want[r]) : '0;
      checks++;
      if (grant_idx[r*IW +: IW] !== e) begin
        fails++;
        $display("FAIL %s lane%0d idx actual=%0d expected=%0d", req, r, grant_idx[r*IW +: IW], e);
      end
    end
    checks++;
    if (issued_mask !== em) begin
      fails++;
      $display("FAIL %s issued_mask actual=%b expected=%b", req, issued_mask, em);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R1 during reset", 4'b0000, 0, 0, 0, 0, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R1 after reset", 4'b0000, 0, 0, 0, 0, 8'h00);
  endtask

  // four consumers in reverse slot order, released together
  task automatic t_four_wide();
    put(7, 31, 20, 0, 0, 1);
    put(5, 31, 20, 0, 0, 1);
    put(3, 31, 20, 0, 0, 1);
    put(1, 31, 20, 0, 0, 1);
    put(0, 20, 0, 1, 0, 1);
    expect_out("R4 waiting entries held", 4'b0000, 0, 0, 0, 0, 8'h00);
    @(negedge clk);
    expect_out("R11 producer granted", 4'b0001, 0, 0, 0, 0, 8'h01);
    @(negedge clk);
    expect_out("R2 age order four lanes", 4'b1111, 7, 5, 3, 1, 8'hAA);
    @(negedge clk);
    expect_out("R7 window drained", 4'b0000, 0, 0, 0, 0, 8'h00);
  endtask

  // middle entry stalls on its second operand, younger one passes it
  task automatic t_skip_stall();
    put(4, 31, 22, 0, 0, 1);
    put(6, 31, 0, 1, 21, 0);
    put(1, 31, 22, 0, 0, 1);
    put(0, 22, 0, 1, 0, 1);
    @(negedge clk);
    expect_out("R3 producer lane0", 4'b0001, 0, 0, 0, 0, 8'h01);
    @(negedge clk);
    expect_out("R4 skip stalled R5 idle lanes", 4'b0011, 4, 1, 0, 0, 8'h12);
    @(negedge clk);
    expect_out("R4 stalled entry stays", 4'b0000, 0, 0, 0, 0, 8'h00);
    put(0, 21, 0, 1, 0, 1);
    @(negedge clk);
    expect_out("R3 second producer", 4'b0001, 0, 0, 0, 0, 8'h01);
    @(negedge clk);
    expect_out("R8 stalled entry released", 4'b0001, 6, 0, 0, 0, 8'h40);
  endtask

  // six ready at once: four now, two next cycle
  task automatic t_overflow();
    for (int s = 6; s >= 1; s--) put(s, 31, 23, 0, 0, 1);
    put(7, 23, 0, 1, 0, 1);
    @(negedge clk);
    expect_out("R6 producer", 4'b0001, 7, 0, 0, 0, 8'h80);
    @(negedge clk);
    expect_out("R6 first four", 4'b1111, 6, 5, 4, 3, 8'h78);
    @(negedge clk);
    expect_out("R6 remaining two", 4'b0011, 2, 1, 0, 0, 8'h06);
    @(negedge clk);
    expect_out("R7 no second grant", 4'b0000, 0, 0, 0, 0, 8'h00);
  endtask

  // three-deep dependency chain, one grant per cycle
  task automatic t_chain();
    put(5, 25, 24, 0, 0, 1);
    put(2, 31, 25, 0, 25, 0);
    put(3, 24, 0, 1, 0, 1);
    expect_out("R11 not before capture", 4'b0000, 0, 0, 0, 0, 8'h00);
    @(negedge clk);
    expect_out("R11 head of chain", 4'b0001, 3, 0, 0, 0, 8'h08);
    @(negedge clk);
    expect_out("R8 second link next cycle", 4'b0001, 5, 0, 0, 0, 8'h20);
    @(negedge clk);
    expect_out("R8 third link next cycle", 4'b0001, 2, 0, 0, 0, 8'h04);
    @(negedge clk);
    expect_out("R7 chain done", 4'b0000, 0, 0, 0, 0, 8'h00);
  endtask

  // entry written in the same cycle its producer broadcasts
  task automatic t_alloc_bypass();
    put(1, 31, 26, 0, 0, 1);
    put(0, 26, 0, 1, 0, 1);
    put(4, 31, 0, 1, 26, 0);
    expect_out("R9 producer on lane0", 4'b0001, 0, 0, 0, 0, 8'h01);
    @(negedge clk);
    expect_out("R9 bypassed operand ready", 4'b0011, 1, 4, 0, 0, 8'h12);
    @(negedge clk);
    expect_out("R7 bypass done", 4'b0000, 0, 0, 0, 0, 8'h00);
  endtask

  // overwrite attempt on an occupied slot must not make it ready
  task automatic t_occupied();
    put(3, 31, 27, 0, 0, 1);
    put(3, 31, 0, 1, 0, 1);
    expect_out("R10 no grant yet", 4'b0000, 0, 0, 0, 0, 8'h00);
    @(negedge clk);
    expect_out("R10 write ignored", 4'b0000, 0, 0, 0, 0, 8'h00);
    put(0, 27, 0, 1, 0, 1);
    @(negedge clk);
    expect_out("R10 producer", 4'b0001, 0, 0, 0, 0, 8'h01);
    @(negedge clk);
    expect_out("R10 original entry kept", 4'b0001, 3, 0, 0, 0, 8'h08);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_four_wide();
    t_skip_stall();
    t_overflow();
    t_chain();
    t_alloc_bypass();
    t_occupied();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule